// File: doc/BRIEF.md
# Serial Controller Interrupt Unit

This block collects the interrupt sources of a serial controller that runs in one of three protocol modes: asynchronous serial with infrared, fast infrared framing, or an enhanced audio codec link. It presents a 16-bit status vector whose bit meanings depend on the selected mode. It also holds a write-only enable mask, and it drives a single registered interrupt line. That line is high when any status bit and its mask bit are both set.

Some status bits mirror live levels from the transmitter, the receiver and the FIFO. The error-class bits are sticky. Each one is set by a one-cycle event pulse and stays set until the controller issues its clear-error command. An event that arrives in a mode where its bit is reserved is dropped. A sticky bit that belongs to another mode reads 0 while that mode is not selected.

Top module: `sci_irq_unit`

## Requirements
- R1: `irq_o` is a register. At each clock edge it takes the OR of (`status_o` AND mask) as it stood before that edge, so a status or mask change reaches `irq_o` one clock later.
- R2: Reset clears the mask to all zeros, clears every sticky bit and drives `irq_o` low.
- R3: The mask is loaded from `mask_wdata_i` on a clock where `mask_we_i` is 1. The mask has no read path and never changes `status_o`.
- R4: Status bit 6 equals `fifo_full_i` when `fifo_thr_sel_i` is 1 and `rx_rdy_i` when it is 0. Status bit 7 equals `tx_rdy_i` in every mode.
- R5: In mode 0 (`mode_i`=00), status bit 4 is the live `tx_empty_i`. In every other mode it is the sticky underrun flag, which is set by `underrun_evt_i`.
- R6: A sticky bit sets on the clock after its event pulse and holds until a clock with `rst_err_i`=1. If the event and `rst_err_i` arrive in the same cycle, the bit ends up set.
- R7: Status bit 5 is a sticky break-change flag, set by `break_evt_i`, in mode 0 only. In any other mode it reads 0 and `break_evt_i` is ignored.
- R8: Status bit 8 is a sticky end-of-frame flag, set by `eof_evt_i`, in mode 1 only. In any other mode it reads 0 and `eof_evt_i` is ignored.
- R9: In mode 2, status bits 12, 13, 14 and 15 are sticky. They are set by `cmd_send_evt_i`, `data_ovr_evt_i`, `data_valid_evt_i` and `unex_slot_evt_i` respectively. In any other mode these bits read 0 and their events are ignored.
- R10: Status bit 9 is a sticky general error flag, set by `error_evt_i` in all modes.
- R11: Status bits 0 to 3, 10 and 11 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 async/IR, 01 fast IR, 10 codec link, 11 plain other |
| fifo_thr_sel_i | input | 1 | Selects the bit 6 source: 1 FIFO threshold, 0 receiver ready |
| tx_empty_i | input | 1 | Transmitter empty level |
| tx_rdy_i | input | 1 | Transmitter ready level |
| rx_rdy_i | input | 1 | Receiver ready level |
| fifo_full_i | input | 1 | Receive FIFO over threshold level |
| underrun_evt_i | input | 1 | Underrun event pulse |
| break_evt_i | input | 1 | Break change event pulse |
| eof_evt_i | input | 1 | End of frame event pulse |
| error_evt_i | input | 1 | General error event pulse |
| cmd_send_evt_i | input | 1 | Codec command sent pulse |
| data_ovr_evt_i | input | 1 | Codec data overwrite pulse |
| data_valid_evt_i | input | 1 | Codec status data valid pulse |
| unex_slot_evt_i | input | 1 | Codec unexpected slot pulse |
| rst_err_i | input | 1 | Clear-error command |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 16 | Mask write data |
| status_o | output | 16 | Status readback |
| irq_o | output | 1 | Interrupt line |

## Verification
A vector table steps the block through all four modes, with each level source turned on by itself and then all of them together. This separates the live mirrors from the mode-gated sticky bits, and it shows whether an event pulse in the wrong mode leaks into state. The same sticky state is read back under different modes, which shows that gating is applied on readout as well as on set. A sequence of mask writes over an unchanged status vector shows that the mask selects which bit raises the line and never changes the readback. Directed cases cover the one-clock interrupt latency, a clear and a set landing in the same cycle, and reset taken while the line is active.

// File: rtl/sci_irq_pkg.sv
package sci_irq_pkg;
  localparam int STAT_W = 16;
  localparam int STK_N  = 8;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_FAST  = 2'b01,
    MODE_CODEC = 2'b10,
    MODE_PLAIN = 2'b11
  } mode_e;

  // sticky slot indices
  localparam int SK_UNDR  = 0;
  localparam int SK_BRK   = 1;
  localparam int SK_EOF   = 2;
  localparam int SK_ERR   = 3;
  localparam int SK_CODEC = 4;  // four codec slots from here
  localparam int N_CODEC  = 4;

  // status bit positions
  localparam int ST_TXE   = 4;
  localparam int ST_BRK   = 5;
  localparam int ST_RX    = 6;
  localparam int ST_TXR   = 7;
  localparam int ST_EOF   = 8;
  localparam int ST_ERR   = 9;
  localparam int ST_CODEC = 12;
endpackage

// File: rtl/sci_irq_decode.sv
module sci_irq_decode
  import sci_irq_pkg::*;
(
  input  mode_e              mode_i,
  output logic [STK_N-1:0]   en_o
);
  logic is_async, is_fast, is_codec;

  assign is_async = (mode_i == MODE_ASYNC);
  assign is_fast  = (mode_i == MODE_FAST);
  assign is_codec = (mode_i == MODE_CODEC);

  always_comb begin
    en_o          = '0;
    en_o[SK_UNDR] = !is_async;
    en_o[SK_BRK]  = is_async;
    en_o[SK_EOF]  = is_fast;
    en_o[SK_ERR]  = 1'b1;
    for (int k = 0; k < N_CODEC; k++) en_o[SK_CODEC+k] = is_codec;
  end
endmodule

// File: rtl/sci_irq_sticky.sv
module sci_irq_sticky #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;  // set beats clear
      else if (clr_i)    q_o[i] <= 1'b0;
    end

    p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]);
    p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i[i]) |=> !q_o[i]);
    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && q_o[i]) |=> q_o[i]);
  end
endmodule

// File: rtl/sci_irq_compose.sv
module sci_irq_compose
  import sci_irq_pkg::*;
(
  input  logic              async_mode_i,
  input  logic              thr_sel_i,
  input  logic              tx_empty_i,
  input  logic              tx_rdy_i,
  input  logic              rx_rdy_i,
  input  logic              fifo_full_i,
  input  logic [STK_N-1:0]  q_i,
  input  logic [STK_N-1:0]  en_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STK_N-1:0] vis;
  assign vis = q_i & en_i;

  always_comb begin
    stat_o         = '0;
    stat_o[ST_TXE] = async_mode_i ? tx_empty_i : vis[SK_UNDR];
    stat_o[ST_BRK] = vis[SK_BRK];
    stat_o[ST_RX]  = thr_sel_i ? fifo_full_i : rx_rdy_i;
    stat_o[ST_TXR] = tx_rdy_i;
    stat_o[ST_EOF] = vis[SK_EOF];
    stat_o[ST_ERR] = vis[SK_ERR];
    for (int k = 0; k < N_CODEC; k++) stat_o[ST_CODEC+k] = vis[SK_CODEC+k];
  end
endmodule

// File: rtl/sci_irq_gate.sv
module sci_irq_gate #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] stat_i,
  output logic         irq_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (we_i) mask_q <= wdata_i;
      irq_o <= |(stat_i & mask_q);
    end
  end

  p_quiet_mask_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |=> !irq_o);
  p_quiet_stat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i == '0) |=> !irq_o);
  p_mask_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/sci_irq_unit.sv
module sci_irq_unit
  import sci_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              fifo_thr_sel_i,
  input  logic              tx_empty_i,
  input  logic              tx_rdy_i,
  input  logic              rx_rdy_i,
  input  logic              fifo_full_i,
  input  logic              underrun_evt_i,
  input  logic              break_evt_i,
  input  logic              eof_evt_i,
  input  logic              error_evt_i,
  input  logic              cmd_send_evt_i,
  input  logic              data_ovr_evt_i,
  input  logic              data_valid_evt_i,
  input  logic              unex_slot_evt_i,
  input  logic              rst_err_i,
  input  logic              mask_we_i,
  input  logic [STAT_W-1:0] mask_wdata_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  mode_e            mode;
  logic [STK_N-1:0] en, evt, q;

  assign mode = mode_e'(mode_i);

  always_comb begin
    evt                = '0;
    evt[SK_UNDR]       = underrun_evt_i;
    evt[SK_BRK]        = break_evt_i;
    evt[SK_EOF]        = eof_evt_i;
    evt[SK_ERR]        = error_evt_i;
    evt[SK_CODEC+0]    = cmd_send_evt_i;
    evt[SK_CODEC+1]    = data_ovr_evt_i;
    evt[SK_CODEC+2]    = data_valid_evt_i;
    evt[SK_CODEC+3]    = unex_slot_evt_i;
  end

  sci_irq_decode u_decode (
    .mode_i (mode),
    .en_o   (en)
  );

  sci_irq_sticky #(.N(STK_N)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt & en),  // events of a foreign mode are dropped
    .clr_i  (rst_err_i),
    .q_o    (q)
  );

  sci_irq_compose u_compose (
    .async_mode_i (mode == MODE_ASYNC),
    .thr_sel_i    (fifo_thr_sel_i),
    .tx_empty_i   (tx_empty_i),
    .tx_rdy_i     (tx_rdy_i),
    .rx_rdy_i     (rx_rdy_i),
    .fifo_full_i  (fifo_full_i),
    .q_i          (q),
    .en_i         (en),
    .stat_o       (status_o)
  );

  sci_irq_gate #(.W(STAT_W)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we_i),
    .wdata_i (mask_wdata_i),
    .stat_i  (status_o),
    .irq_o   (irq_o)
  );

  p_brk_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (break_evt_i && mode != MODE_ASYNC && !q[SK_BRK]) |=> !q[SK_BRK]);
  p_eof_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_evt_i && mode != MODE_FAST && !q[SK_EOF]) |=> !q[SK_EOF]);
  p_codec_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != MODE_CODEC) |-> (status_o[ST_CODEC +: N_CODEC] == '0));
  p_err_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_evt_i |=> status_o[ST_ERR]);
endmodule

// File: tb/sci_irq_unit_tb_top.sv
module sci_irq_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  typedef struct packed {
    logic [1:0]  mode;
    logic        thr;
    logic [3:0]  lv;    // {tx_empty, tx_rdy, rx_rdy, fifo_full}
    logic [7:0]  ev;    // {unex, valid, ovr, cmd, error, eof, brk, underrun}
    logic        clr;
    logic        mwe;
    logic [15:0] mdata;
    logic [15:0] stat;
    logic        irq;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd0,1'b0,4'b0000,8'h00,1'b0,1'b1,16'hFFFF,16'h0000,1'b0}, // R3 R11
    '{2'd0,1'b0,4'b1000,8'h00,1'b0,1'b0,16'h0000,16'h0010,1'b1}, // R5
    '{2'd0,1'b0,4'b0010,8'h00,1'b0,1'b0,16'h0000,16'h0040,1'b1}, // R4
    '{2'd0,1'b1,4'b0010,8'h00,1'b0,1'b0,16'h0000,16'h0000,1'b0}, // R4
    '{2'd0,1'b1,4'b0001,8'h00,1'b0,1'b0,16'h0000,16'h0040,1'b1}, // R4
    '{2'd0,1'b0,4'b0100,8'h00,1'b0,1'b0,16'h0000,16'h0080,1'b1}, // R4
    '{2'd0,1'b0,4'b0000,8'h02,1'b0,1'b0,16'h0000,16'h0020,1'b1}, // R7
    '{2'd0,1'b0,4'b0000,8'h05,1'b0,1'b0,16'h0000,16'h0020,1'b1}, // R8 R5
    '{2'd0,1'b0,4'b0000,8'h00,1'b1,1'b0,16'h0000,16'h0000,1'b0}, // R6
    '{2'd1,1'b0,4'b0000,8'h05,1'b0,1'b0,16'h0000,16'h0110,1'b1}, // R8 R5
    '{2'd1,1'b0,4'b0000,8'h00,1'b0,1'b1,16'h0010,16'h0110,1'b1}, // R3
    '{2'd1,1'b0,4'b0000,8'h00,1'b0,1'b1,16'h0100,16'h0110,1'b1}, // R3
    '{2'd1,1'b0,4'b0000,8'h00,1'b0,1'b1,16'h0200,16'h0110,1'b0}, // R3 R1
    '{2'd1,1'b0,4'b0000,8'h08,1'b1,1'b0,16'h0000,16'h0200,1'b1}, // R6 R10
    '{2'd2,1'b0,4'b0000,8'hF0,1'b0,1'b1,16'hF000,16'hF200,1'b1}, // R9
    '{2'd2,1'b0,4'b0000,8'h02,1'b0,1'b0,16'h0000,16'hF200,1'b1}, // R7
    '{2'd0,1'b0,4'b0000,8'h00,1'b0,1'b0,16'h0000,16'h0200,1'b0}, // R9
    '{2'd2,1'b0,4'b0000,8'h00,1'b1,1'b0,16'h0000,16'h0000,1'b0}, // R6
    '{2'd2,1'b0,4'b0000,8'h10,1'b0,1'b1,16'h2000,16'h1000,1'b0}, // R9 R1
    '{2'd2,1'b0,4'b0000,8'h20,1'b0,1'b0,16'h0000,16'h3000,1'b1}, // R9
    '{2'd3,1'b0,4'b1111,8'h00,1'b0,1'b0,16'h0000,16'h00C0,1'b0}, // R5 R11
    '{2'd2,1'b0,4'b0000,8'h00,1'b0,1'b1,16'hFFFF,16'h3000,1'b1}, // R9
    '{2'd0,1'b1,4'b1111,8'h00,1'b0,1'b1,16'h0000,16'h00D0,1'b0}  // R4 R5
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        fifo_thr_sel_i = 1'b0;
  logic        tx_empty_i = 1'b0, tx_rdy_i = 1'b0, rx_rdy_i = 1'b0, fifo_full_i = 1'b0;
  logic        underrun_evt_i = 1'b0, break_evt_i = 1'b0, eof_evt_i = 1'b0, error_evt_i = 1'b0;
  logic        cmd_send_evt_i = 1'b0, data_ovr_evt_i = 1'b0, data_valid_evt_i = 1'b0;
  logic        unex_slot_evt_i = 1'b0;
  logic        rst_err_i = 1'b0, mask_we_i = 1'b0;
  logic [15:0] mask_wdata_i = '0;
  logic [15:0] status_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sci_irq_unit dut_i (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ev(logic [7:0] ev);
    {unex_slot_evt_i, data_valid_evt_i, data_ovr_evt_i, cmd_send_evt_i,
     error_evt_i, eof_evt_i, break_evt_i, underrun_evt_i} = ev;
  endtask

  task automatic run_vec(vec_t v, int idx);
    @(negedge clk_i);
    mode_i = v.mode;
    fifo_thr_sel_i = v.thr;
    {tx_empty_i, tx_rdy_i, rx_rdy_i, fifo_full_i} = v.lv;
    set_ev(v.ev);
    rst_err_i = v.clr;
    mask_we_i = v.mwe;
    mask_wdata_i = v.mdata;
    @(posedge clk_i); #1;
    set_ev(8'h00);
    rst_err_i = 1'b0;
    mask_we_i = 1'b0;
    check($sformatf("table %0d status", idx), status_o, v.stat);
    @(posedge clk_i); #1;
    check($sformatf("table %0d irq", idx), {15'd0, irq_o}, {15'd0, v.irq});
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*3);
    check("R2 reset status", status_o, 16'h0000);
    check("R2 reset irq", {15'd0, irq_o}, 16'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R1: latency of exactly one clock
    @(negedge clk_i);
    mode_i = 2'd0; fifo_thr_sel_i = 1'b0;
    {tx_empty_i, tx_rdy_i, rx_rdy_i, fifo_full_i} = 4'b0000;
    mask_we_i = 1'b1; mask_wdata_i = 16'h0010;
    @(posedge clk_i); #1; mask_we_i = 1'b0;
    @(posedge clk_i); #1;
    check("R1 idle irq", {15'd0, irq_o}, 16'h0);
    @(negedge clk_i); tx_empty_i = 1'b1; #1;
    check("R1 irq before edge", {15'd0, irq_o}, 16'h0);
    @(posedge clk_i); #1;
    check("R1 irq after edge", {15'd0, irq_o}, 16'h1);
    @(negedge clk_i); tx_empty_i = 1'b0;
    @(posedge clk_i); #1;
    check("R1 irq drop", {15'd0, irq_o}, 16'h0);

    // R6/R10: set and clear together on an already set bit
    @(negedge clk_i); error_evt_i = 1'b1;
    @(negedge clk_i); rst_err_i = 1'b1;
    @(negedge clk_i); error_evt_i = 1'b0; rst_err_i = 1'b0;
    check("R6 set wins", status_o, 16'h0200);
    @(negedge clk_i); rst_err_i = 1'b1;
    @(negedge clk_i); rst_err_i = 1'b0;
    check("R6 clear", status_o, 16'h0000);

    // R2: reset mid-run drops the mask
    @(negedge clk_i); tx_empty_i = 1'b1;
    @(posedge clk_i); #1;
    check("R2 pre-reset irq", {15'd0, irq_o}, 16'h1);
    @(negedge clk_i); rst_ni = 1'b0; #1;
    check("R2 irq in reset", {15'd0, irq_o}, 16'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    @(posedge clk_i); #1;
    check("R2 mask cleared", {15'd0, irq_o}, 16'h0);
    check("R5 live after reset", status_o, 16'h0010);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule